// File: doc/BRIEF.md
# Pulse-Skipping Overcurrent Limiter

This block sits between the PWM comparator and the gate driver of a step-down converter's power switch. Within each switching cycle it passes the PWM on-request to the gate and checks a digital overcurrent flag once per pulse. The flag is ignored for a programmable number of clocks after turn-on. This masks the switching noise at the leading edge of the pulse.

When the flag is high at the end of the mask, the pulse is cut short at once. An adaptive skip counter then rises by one, and that many following cycles are suppressed completely. A pulse that ends clean lowers the counter by one. Under a sustained short the counter stops at seven. The switch then fires only once every eight cycles, which holds the average current near the limit. The analog current sense and its threshold stay outside the block, which only sees the comparator result.

Top module: `ocp_pulse_skipper`

## Requirements
- R1: While reset is held and on the first clock after it, skip_count is 0, gate_on is 0 and oc_event is 0.
- R2: In a cycle that is allowed to conduct, gate_on equals pwm_on in the same clock, and it goes low in the same clock that pwm_on goes low.
- R3: oc_comp has no effect during the first BLANK_CYC clocks in which gate_on is high in a cycle. The gate stays on and no event is flagged, whatever oc_comp does in that window.
- R4: If oc_comp is high on the clock edge that ends the blanking window (the BLANK_CYC-th clock of conduction), gate_on is low from the next clock until the next cycle_start. oc_event is high for exactly that one following clock.
- R5: Each pulse cut by overcurrent raises skip_count by one, up to a maximum of MAX_SKIP (7).
- R6: After a pulse cut by overcurrent, the next N cycle_start pulses begin skipped cycles, where N is the new skip_count. In a skipped cycle gate_on stays low for the whole cycle, whatever pwm_on does.
- R7: A pulse that is still on and has oc_comp low at the end of blanking lowers skip_count by one, with zero as the floor.
- R8: A pulse whose pwm_on ends before the blanking window expires counts as clean. skip_count drops by one (floor zero), and oc_comp is never sampled in that cycle.
- R9: skip_count never moves by more than one step between two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycle_start | input | 1 | One-clock pulse that opens a switching cycle |
| pwm_on | input | 1 | On-request from the PWM comparator |
| oc_comp | input | 1 | Overcurrent comparator result, high means over the limit |
| gate_on | output | 1 | Power-switch gate command |
| skip_count | output | SKIP_W | Current adaptive skip count |
| oc_event | output | 1 | One-clock pulse when a pulse is cut by overcurrent |

## Verification
The assertions assume that pwm_on is low on the clock when cycle_start is high. They also assume that at most one on-request occurs per switching cycle, so each cycle yields at most one clean or overcurrent verdict. The stimulus meets these assumptions by construction. Every cycle drives cycle_start for one clock with pwm_on low, then a single on-request of 1 to PERIOD-2 clocks, and it ends that request at least one clock before the next cycle_start. Inside the blanking window oc_comp is random. From the sampling clock onward it holds the value chosen for the pulse, so the outcome of each pulse is defined.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    // Default blanking length: 200 ns at a 250 MHz clock
    localparam int DEF_BLANK_CYC = 50;
    localparam int DEF_MAX_SKIP  = 7;

    // Verdict produced once per conduction pulse
    typedef struct packed {
        logic over;   // pulse cut by overcurrent
        logic clean;  // pulse judged clean
    } ocp_verdict_t;

    function automatic int skip_up(input int cur, input int lim);
        return (cur >= lim) ? lim : cur + 1;
    endfunction

    function automatic int skip_down(input int cur);
        return (cur == 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer
    import ocp_pkg::*;
#(
    parameter int BLANK_CYC = DEF_BLANK_CYC,
    localparam int BW = $clog2(BLANK_CYC + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cycle_start,
    input  logic         gate_on,
    input  logic         pwm_on,
    input  logic         oc_comp,
    output ocp_verdict_t verdict
);
    localparam logic [BW-1:0] LAST = BW'(BLANK_CYC - 1);

    logic [BW-1:0] on_cnt;
    logic          judged;
    logic          at_end;
    logic          early_off;

    assign at_end    = gate_on && !judged && (on_cnt == LAST);
    assign early_off = !judged && !pwm_on && (on_cnt != '0);

    always_comb begin
        verdict.over  = at_end && oc_comp;
        verdict.clean = (at_end && !oc_comp) || early_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_cnt <= '0;
            judged <= 1'b0;
        end else if (cycle_start) begin
            on_cnt <= '0;
            judged <= 1'b0;
        end else if (verdict.over || verdict.clean) begin
            judged <= 1'b1;
        end else if (gate_on && !judged) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

    // R3
    blank_window_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_on && !judged && on_cnt < LAST) |-> !verdict.over);

    // R8
    one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        (judged && !cycle_start) |-> !(verdict.over || verdict.clean));

endmodule

// File: rtl/ocp_skip_ctrl.sv
module ocp_skip_ctrl
    import ocp_pkg::*;
#(
    parameter int MAX_SKIP = DEF_MAX_SKIP,
    localparam int SW = $clog2(MAX_SKIP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cycle_start,
    input  ocp_verdict_t  verdict,
    output logic [SW-1:0] skip_count,
    output logic          skipping
);
    logic [SW-1:0] skips_left;
    logic [SW-1:0] count_up;
    logic [SW-1:0] count_dn;

    assign count_up = SW'(skip_up(int'(skip_count), MAX_SKIP));
    assign count_dn = SW'(skip_down(int'(skip_count)));

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_count <= '0;
            skips_left <= '0;
            skipping   <= 1'b0;
        end else begin
            if (verdict.over)
                skip_count <= count_up;
            else if (verdict.clean)
                skip_count <= count_dn;

            if (verdict.over)
                skips_left <= count_up;
            else if (cycle_start && skips_left != '0)
                skips_left <= skips_left - 1'b1;

            if (cycle_start)
                skipping <= (skips_left != '0);
        end
    end

    // R5
    skip_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        skip_count <= SW'(MAX_SKIP));

    // R9
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(skip_count) |->
            (skip_count == $past(skip_count) + 1'b1 || skip_count == $past(skip_count) - 1'b1));

    // R6
    left_bound_chk: assert property (@(posedge clk) disable iff (rst)
        skips_left <= skip_count);

endmodule

// File: rtl/ocp_pulse_skipper.sv
module ocp_pulse_skipper
    import ocp_pkg::*;
#(
    parameter int BLANK_CYC = DEF_BLANK_CYC,
    parameter int MAX_SKIP  = DEF_MAX_SKIP,
    localparam int SKIP_W   = $clog2(MAX_SKIP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cycle_start,
    input  logic              pwm_on,
    input  logic              oc_comp,
    output logic              gate_on,
    output logic [SKIP_W-1:0] skip_count,
    output logic              oc_event
);
    ocp_verdict_t verdict;
    logic         skipping;
    logic         cut_off;

    ocp_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk         (clk),
        .rst         (rst),
        .cycle_start (cycle_start),
        .gate_on     (gate_on),
        .pwm_on      (pwm_on),
        .oc_comp     (oc_comp),
        .verdict     (verdict)
    );

    ocp_skip_ctrl #(.MAX_SKIP(MAX_SKIP)) u_skip (
        .clk         (clk),
        .rst         (rst),
        .cycle_start (cycle_start),
        .verdict     (verdict),
        .skip_count  (skip_count),
        .skipping    (skipping)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cut_off  <= 1'b0;
            oc_event <= 1'b0;
        end else begin
            oc_event <= verdict.over;
            if (cycle_start)
                cut_off <= 1'b0;
            else if (verdict.over)
                cut_off <= 1'b1;
        end
    end

    assign gate_on = pwm_on && !skipping && !cut_off;

    // R4
    event_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        oc_event |-> !gate_on);

    // R4
    event_single_chk: assert property (@(posedge clk) disable iff (rst)
        oc_event |=> !oc_event);

    // R5
    event_raises_chk: assert property (@(posedge clk) disable iff (rst)
        oc_event |-> (skip_count == SKIP_W'(MAX_SKIP) || skip_count != $past(skip_count, 2)));

endmodule

// File: tb/ocp_pulse_skipper_tb.sv
module ocp_pulse_skipper_tb;
    localparam int BLANK  = 50;
    localparam int MAXS   = 7;
    localparam int PERIOD = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cycle_start = 1'b0;
    logic       pwm_on = 1'b0;
    logic       oc_comp = 1'b0;
    logic       gate_on;
    logic [2:0] skip_count;
    logic       oc_event;

    int checks = 0;
    int errors = 0;
    int m_cnt  = 0;
    int m_left = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ocp_pulse_skipper #(.BLANK_CYC(BLANK), .MAX_SKIP(MAXS)) u_dut (
        .clk(clk), .rst(rst), .cycle_start(cycle_start), .pwm_on(pwm_on),
        .oc_comp(oc_comp), .gate_on(gate_on), .skip_count(skip_count),
        .oc_event(oc_event)
    );

    function automatic int ref_up(input int c);
        return (c >= MAXS) ? MAXS : c + 1;
    endfunction

    function automatic int ref_dn(input int c);
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One switching cycle: on-request of w clocks, oc level from the sampling clock on
    task automatic run_cycle(input int w, input bit oc);
        int hi = 0;
        int ev = 0;
        int exp_hi;
        int exp_ev;
        bit skipped;
        @(negedge clk);
        cycle_start = 1'b1;
        pwm_on      = 1'b0;
        oc_comp     = 1'($urandom % 2);
        @(negedge clk);
        cycle_start = 1'b0;
        for (int k = 0; k < PERIOD - 1; k++) begin
            pwm_on  = (k < w);
            oc_comp = (k >= BLANK - 1) ? oc : 1'($urandom % 2);
            #1;
            if (gate_on) hi++;
            if (oc_event) ev++;
            @(negedge clk);
        end
        pwm_on = 1'b0;
        skipped = (m_left != 0);
        if (skipped) begin
            m_left--;
            exp_hi = 0;
            exp_ev = 0;
        end else if (w >= BLANK && oc) begin
            exp_hi = BLANK;
            exp_ev = 1;
            m_cnt  = ref_up(m_cnt);
            m_left = m_cnt;
        end else begin
            exp_hi = w;
            exp_ev = 0;
            m_cnt  = ref_dn(m_cnt);
        end
        if (skipped)
            check(hi, exp_hi, "R6 skipped cycle gate clocks");
        else if (w < BLANK)
            check(hi, exp_hi, "R2,R3,R8 short pulse gate clocks");
        else
            check(hi, exp_hi, "R2,R3,R4 gate clocks");
        check(ev, exp_ev, "R4 oc_event count");
        if (w < BLANK && !skipped)
            check(int'(skip_count), m_cnt, "R8 skip_count after early end");
        else
            check(int'(skip_count), m_cnt, "R5,R7 skip_count");
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #1;
        // R1
        check(int'(skip_count), 0, "R1 skip_count in reset");
        check(int'(gate_on), 0, "R1 gate_on in reset");
        check(int'(oc_event), 0, "R1 oc_event in reset");
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(int'(skip_count), 0, "R1 skip_count after reset");

        // R3: heavy noise during blanking, clean afterwards
        run_cycle(70, 1'b0);
        // R8: short pulse with oc high at the end is still clean
        run_cycle(20, 1'b1);
        // pulse exactly as long as blanking is sampled
        run_cycle(BLANK, 1'b1);
        // R5, R6: sustained short drives the count to its ceiling
        for (int i = 0; i < 40; i++) run_cycle(70, 1'b1);
        check(int'(skip_count), MAXS, "R5 saturated at seven");
        // R7: clean pulses decay the count to the floor
        for (int i = 0; i < 12; i++) run_cycle(60, 1'b0);
        check(int'(skip_count), 0, "R7 floor at zero");
        // R8 at the floor
        run_cycle(1, 1'b0);

        for (int i = 0; i < 250; i++) begin
            int w;
            bit oc;
            w  = 1 + int'($urandom % (PERIOD - 2));
            oc = ($urandom % 3) != 0;
            run_cycle(w, oc);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule